// File: doc/BRIEF.md
# 1-Wire ROM Search Controller

This block runs the binary-tree enumeration that finds the 64-bit identifiers of every device sharing a 1-Wire bus. It does not generate slot timing itself. It sends one slot request at a time (reset, read or write) to an external bit-slot engine, and it consumes that engine's completion strobe and sampled bus bit. A single `start` pulse runs the whole search. The block makes as many passes as the tree requires. Each pass opens with a bus reset and the search command, then walks every identifier bit with a read/read/write triple.

At a position where devices disagree, the branch is chosen from two remembered positions. These are the deepest position where the zero branch was taken in the latest pass, and the one before it. The choice is also guided by the identifier found in the previous pass. Together these decide which branch is taken and whether a further pass is still owed. Every completed identifier is checked against an externally computed CRC byte before it is counted. The first identifiers up to a parameter limit are streamed out with a one-cycle valid strobe. A one-cycle done pulse closes the search, and at that point the device count and the error flag are held for reading.

Top module: `ow_tree_search`

## Requirements
- R1: After synchronous reset, `busy`, `slot_req`, `id_valid`, `search_done` and `search_err` are low and `dev_count` is 0.
- R2: Every pass opens with one reset slot (`slot_kind` = 0). If that slot returns `slot_rbit` = 0 (no presence), the search ends with a `search_done` pulse, `dev_count` = 0 and `search_err` = 0.
- R3: After a presence response, eight write slots (`slot_kind` = 2) carry the command byte 0xF0, least significant bit first.
- R4: For each identifier bit, from position 0 upwards, the block issues a read slot (`slot_kind` = 1) for the true bit, then a read slot for the complement, then one write slot. No other slot type is interleaved.
- R5: If both reads of a position return 1, the search stops: `search_err` = 1, `dev_count` = 0, a `search_done` pulse, and no further slot request.
- R6: If exactly one of the two reads returns 1, the written bit equals the true-bit read, and that value is stored at that position of the identifier.
- R7: When both reads return 0, the first pass takes the 0 branch. Later passes choose using the two remembered zero-branch positions and the previous identifier. As a result, every device is reported exactly once, in ascending order of its identifier read least significant bit first.
- R8: The top byte of a finished identifier (bits ID_BITS-1 down to ID_BITS-8) must equal `crc_in`, which is computed outside the block over `crc_data` (bits ID_BITS-9 down to 0). On a mismatch the search ends with `search_err` = 1 and `dev_count` = 0.
- R9: Each identifier that passes the CRC check adds one to `dev_count`. When a pass finishes with no further pass owed, the search ends with a one-cycle `search_done` pulse.
- R10: Only the first MAX_DEV accepted identifiers raise `id_valid`, with `id_data` holding the identifier. Later identifiers are still counted in `dev_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (taken only while idle) |
| slot_req | output | 1 | A slot is requested from the bit-slot engine |
| slot_kind | output | 2 | Slot type: 0 reset, 1 read, 2 write |
| slot_wbit | output | 1 | Bit to write in a write slot |
| slot_done | input | 1 | One-cycle strobe: requested slot finished |
| slot_rbit | input | 1 | Sampled bus bit, or presence for a reset slot |
| crc_data | output | ID_BITS-8 | Identifier bits covered by the CRC |
| crc_in | input | 8 | CRC computed outside the block over `crc_data` |
| id_valid | output | 1 | One-cycle strobe for a reported identifier |
| id_data | output | ID_BITS | Reported identifier |
| dev_count | output | CNT_W | Number of identifiers accepted |
| search_err | output | 1 | Search ended in error |
| search_done | output | 1 | One-cycle pulse at the end of a search |
| busy | output | 1 | A search is in progress |

## Verification
The bench builds the block with ID_BITS = 16, MAX_DEV = 3 and CNT_W = 4, so that each identifier is one data byte plus its CRC byte and a pass takes only 57 slots. At that size, every subset of a five-identifier pool with shared prefixes can be enumerated. This covers empty buses, single devices and collision trees several levels deep. With four or five devices present, the sweep runs past the output cap. A bus that answers presence but drives no bits, and identifiers with a corrupted CRC byte, drive the two error exits.

// File: rtl/ow_search_pkg.sv
package ow_search_pkg;

    // Slot types requested from the external bit-slot engine.
    typedef enum logic [1:0] {
        SLOT_RESET = 2'd0,
        SLOT_READ  = 2'd1,
        SLOT_WRITE = 2'd2
    } slot_kind_e;

    // Search sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_CMD,
        ST_RDD,
        ST_RDC,
        ST_WR,
        ST_CHK,
        ST_FIN
    } seq_state_e;

    // Branch decision result for one bit position.
    typedef struct packed {
        logic take;   // bit to write and record
        logic more;   // another pass is owed
    } branch_t;

    localparam logic [7:0] SEARCH_CMD = 8'hF0;
    localparam int         CMD_BITS   = 8;

    // True when both the bit and its complement read high: nobody answered.
    function automatic logic pair_void(input logic dir_b, input logic cmp_b);
        return dir_b & cmp_b;
    endfunction

    // True when devices disagree at this position.
    function automatic logic pair_split(input logic dir_b, input logic cmp_b);
        return ~dir_b & ~cmp_b;
    endfunction

endpackage

// File: rtl/ow_branch_unit.sv
module ow_branch_unit
    import ow_search_pkg::*;
#(
    parameter int ID_BITS = 64,
    localparam int IDX_W = $clog2(ID_BITS),
    localparam int MK_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             decide,
    input  logic             first_pass,
    input  logic             dir_bit,
    input  logic             cmp_bit,
    input  logic [IDX_W-1:0] pos,
    input  logic             prev_bit,
    output branch_t          choice
);

    // Remembered zero-branch positions; -1 means none.
    logic signed [MK_W-1:0] last_z;
    logic signed [MK_W-1:0] prev_z;
    logic signed [MK_W-1:0] last_n;
    logic signed [MK_W-1:0] prev_n;
    logic signed [MK_W-1:0] pos_s;

    assign pos_s = $signed({1'b0, pos});

    always_comb begin
        last_n      = last_z;
        prev_n      = prev_z;
        choice.take = dir_bit;
        choice.more = 1'b0;
        if (pair_split(dir_bit, cmp_bit)) begin
            if (!first_pass && pos_s < last_z) begin
                // Retrace the previous path below the deepest zero branch.
                choice.take = prev_bit;
                if (!prev_bit) begin
                    prev_n      = pos_s;
                    choice.more = 1'b1;
                end
            end else if (!first_pass && pos_s == last_z) begin
                // Deepest zero branch now flips to the one side.
                choice.take = 1'b1;
                last_n      = prev_z;
            end else begin
                // New fork deeper than anything seen: go zero first.
                choice.take = 1'b0;
                prev_n      = last_z;
                last_n      = pos_s;
                choice.more = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || init) begin
            last_z <= '1;
            prev_z <= '1;
        end else if (decide) begin
            last_z <= last_n;
            prev_z <= prev_n;
        end
    end

    // R7: the older marker never lies deeper than the newer one.
    a_r7_marker_order: assert property (@(posedge clk) disable iff (rst)
        last_z >= prev_z);

    // R7: a fork seen on the first pass always yields a pending pass.
    a_r7_first_fork_more: assert property (@(posedge clk) disable iff (rst)
        (decide && first_pass && !dir_bit && !cmp_bit) |-> choice.more && !choice.take);

endmodule

// File: rtl/ow_path_store.sv
module ow_path_store #(
    parameter int ID_BITS = 64,
    localparam int IDX_W = $clog2(ID_BITS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init,
    input  logic               clear_cur,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   pos,
    input  logic               set_val,
    input  logic               commit,
    output logic [ID_BITS-1:0] cur_path,
    output logic               prev_bit
);

    logic [ID_BITS-1:0] cur_q;
    logic [ID_BITS-1:0] prev_q;

    for (genvar i = 0; i < ID_BITS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clear_cur)
                cur_q[i] <= 1'b0;
            else if (set_en && pos == IDX_W'(i))
                cur_q[i] <= set_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || init)
            prev_q <= '0;
        else if (commit)
            prev_q <= cur_q;
    end

    assign cur_path = cur_q;
    assign prev_bit = prev_q[pos];

    // R7: an accepted identifier becomes the path retraced next pass.
    a_r7_commit_copy: assert property (@(posedge clk) disable iff (rst)
        (commit && !init) |=> prev_q == $past(cur_q));

    // R6: a recorded bit lands at the addressed position.
    a_r6_bit_recorded: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clear_cur) |=> cur_q[$past(pos)] == $past(set_val));

endmodule

// File: rtl/ow_tree_search.sv
module ow_tree_search
    import ow_search_pkg::*;
#(
    parameter int ID_BITS = 64,
    parameter int MAX_DEV = 8,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               slot_req,
    output logic [1:0]         slot_kind,
    output logic               slot_wbit,
    input  logic               slot_done,
    input  logic               slot_rbit,
    output logic [ID_BITS-9:0] crc_data,
    input  logic [7:0]         crc_in,
    output logic               id_valid,
    output logic [ID_BITS-1:0] id_data,
    output logic [CNT_W-1:0]   dev_count,
    output logic               search_err,
    output logic               search_done,
    output logic               busy
);

    localparam int IDX_W  = $clog2(ID_BITS);
    localparam int CIDX_W = $clog2(CMD_BITS);

    seq_state_e          st;
    slot_kind_e          kind;
    logic [IDX_W-1:0]    pos_q;
    logic [CIDX_W-1:0]   cmd_idx;
    logic                dir_q;
    logic                wbit_q;
    logic                first_q;
    logic                more_q;
    logic                err_q;
    logic                valid_q;
    logic                done_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [ID_BITS-1:0]  id_q;

    logic                init_s;
    logic                clear_s;
    logic                decide_s;
    logic                commit_s;
    logic                crc_ok;
    logic                prev_bit;
    logic [ID_BITS-1:0]  cur_path;
    branch_t             choice;

    // Control strobes shared by the sub-blocks.
    assign init_s   = (st == ST_IDLE) && start;
    assign clear_s  = (st == ST_RST) && slot_done && slot_rbit;
    assign decide_s = (st == ST_RDC) && slot_done && !pair_void(dir_q, slot_rbit);
    assign crc_ok   = cur_path[ID_BITS-1 -: 8] == crc_in;
    assign commit_s = (st == ST_CHK) && crc_ok;

    ow_path_store #(.ID_BITS(ID_BITS)) u_path (
        .clk       (clk),
        .rst       (rst),
        .init      (init_s),
        .clear_cur (clear_s),
        .set_en    (decide_s),
        .pos       (pos_q),
        .set_val   (choice.take),
        .commit    (commit_s),
        .cur_path  (cur_path),
        .prev_bit  (prev_bit)
    );

    ow_branch_unit #(.ID_BITS(ID_BITS)) u_branch (
        .clk        (clk),
        .rst        (rst),
        .init       (init_s),
        .decide     (decide_s),
        .first_pass (first_q),
        .dir_bit    (dir_q),
        .cmp_bit    (slot_rbit),
        .pos        (pos_q),
        .prev_bit   (prev_bit),
        .choice     (choice)
    );

    // Slot request decode.
    always_comb begin
        slot_req  = 1'b0;
        kind      = SLOT_READ;
        slot_wbit = 1'b0;
        unique case (st)
            ST_RST: begin
                slot_req = 1'b1;
                kind     = SLOT_RESET;
            end
            ST_CMD: begin
                slot_req  = 1'b1;
                kind      = SLOT_WRITE;
                slot_wbit = SEARCH_CMD[cmd_idx];
            end
            ST_RDD, ST_RDC: begin
                slot_req = 1'b1;
                kind     = SLOT_READ;
            end
            ST_WR: begin
                slot_req  = 1'b1;
                kind      = SLOT_WRITE;
                slot_wbit = wbit_q;
            end
            default: ;
        endcase
    end

    // Search sequencer.
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            pos_q   <= '0;
            cmd_idx <= '0;
            dir_q   <= 1'b0;
            wbit_q  <= 1'b0;
            first_q <= 1'b0;
            more_q  <= 1'b0;
            err_q   <= 1'b0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            cnt_q   <= '0;
            id_q    <= '0;
        end else begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    err_q   <= 1'b0;
                    cnt_q   <= '0;
                    first_q <= 1'b1;
                    st      <= ST_RST;
                end
                ST_RST: if (slot_done) begin
                    if (!slot_rbit) begin
                        cnt_q <= '0;
                        st    <= ST_FIN;
                    end else begin
                        more_q  <= 1'b0;
                        pos_q   <= '0;
                        cmd_idx <= '0;
                        st      <= ST_CMD;
                    end
                end
                ST_CMD: if (slot_done) begin
                    if (cmd_idx == CIDX_W'(CMD_BITS - 1))
                        st <= ST_RDD;
                    else
                        cmd_idx <= cmd_idx + 1'b1;
                end
                ST_RDD: if (slot_done) begin
                    dir_q <= slot_rbit;
                    st    <= ST_RDC;
                end
                ST_RDC: if (slot_done) begin
                    if (pair_void(dir_q, slot_rbit)) begin
                        err_q <= 1'b1;
                        cnt_q <= '0;
                        st    <= ST_FIN;
                    end else begin
                        wbit_q <= choice.take;
                        more_q <= more_q | choice.more;
                        st     <= ST_WR;
                    end
                end
                ST_WR: if (slot_done) begin
                    if (pos_q == IDX_W'(ID_BITS - 1)) begin
                        st <= ST_CHK;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                        st    <= ST_RDD;
                    end
                end
                ST_CHK: begin
                    if (!crc_ok) begin
                        err_q <= 1'b1;
                        cnt_q <= '0;
                        st    <= ST_FIN;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        first_q <= 1'b0;
                        if (cnt_q < CNT_W'(MAX_DEV)) begin
                            valid_q <= 1'b1;
                            id_q    <= cur_path;
                        end
                        st <= more_q ? ST_RST : ST_FIN;
                    end
                end
                ST_FIN: begin
                    done_q <= 1'b1;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign slot_kind   = kind;
    assign crc_data    = cur_path[ID_BITS-9:0];
    assign id_valid    = valid_q;
    assign id_data     = id_q;
    assign dev_count   = cnt_q;
    assign search_err  = err_q;
    assign search_done = done_q;
    assign busy        = (st != ST_IDLE);

    // R1: nothing is requested or reported while idle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !slot_req && !id_valid);

    // R4: a pending request keeps its type and data until completion.
    a_r4_slot_hold: assert property (@(posedge clk) disable iff (rst)
        (slot_req && !slot_done) |=> $stable(slot_kind) && $stable(slot_wbit));

    // R4: a completed complement read is followed by the write or the stop.
    a_r4_write_follows: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RDC && slot_done) |=> (st == ST_WR || st == ST_FIN));

    // R5: a silent bit pair ends the search in error with a zero count.
    a_r5_void_stop: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RDC && slot_done && dir_q && slot_rbit) |=>
            (search_err && dev_count == '0 && !slot_req));

    // R2: an absent presence response ends the search without error.
    a_r2_no_presence: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RST && slot_done && !slot_rbit) |=>
            (st == ST_FIN && dev_count == '0 && !search_err));

    // R9: the done indication lasts one cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        search_done |=> !search_done);

    // R10: a reported identifier never exceeds the output cap.
    a_r10_emit_cap: assert property (@(posedge clk) disable iff (rst)
        id_valid |-> (dev_count <= CNT_W'(MAX_DEV) && dev_count != '0));

endmodule

// File: tb/sim_ow_tree_search.sv
module sim_ow_tree_search;

    localparam int IDB  = 16;
    localparam int MAXD = 3;
    localparam int CW   = 4;
    localparam int NP   = 5;

    logic            clk = 1'b0;
    logic            rst;
    logic            start;
    logic            slot_req;
    logic [1:0]      slot_kind;
    logic            slot_wbit;
    logic            slot_done;
    logic            slot_rbit;
    logic [IDB-9:0]  crc_data;
    logic [7:0]      crc_in;
    logic            id_valid;
    logic [IDB-1:0]  id_data;
    logic [CW-1:0]   dev_count;
    logic            search_err;
    logic            search_done;
    logic            busy;

    always #5 clk = ~clk;

    ow_tree_search #(.ID_BITS(IDB), .MAX_DEV(MAXD), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .slot_req(slot_req), .slot_kind(slot_kind), .slot_wbit(slot_wbit),
        .slot_done(slot_done), .slot_rbit(slot_rbit),
        .crc_data(crc_data), .crc_in(crc_in),
        .id_valid(id_valid), .id_data(id_data), .dev_count(dev_count),
        .search_err(search_err), .search_done(search_done), .busy(busy)
    );

    // External CRC: reflected polynomial 0x8C, bits consumed LSB first.
    function automatic logic [7:0] crc8(input logic [IDB-9:0] d);
        logic [7:0] c;
        logic m;
        c = 8'h00;
        for (int i = 0; i < IDB - 8; i++) begin
            m = c[0] ^ d[i];
            c = c >> 1;
            if (m) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    assign crc_in = crc8(crc_data);

    function automatic logic [IDB-1:0] rev(input logic [IDB-1:0] v);
        logic [IDB-1:0] r;
        for (int i = 0; i < IDB; i++) r[i] = v[IDB-1-i];
        return r;
    endfunction

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [IDB-1:0] ids [NP];
    logic [NP-1:0]  pres;
    logic           ghost;
    logic [NP-1:0]  act;
    int             cmd_n;
    int             sub;
    int             bpos;
    logic [7:0]     cmd_v;
    bit             cmd_bad;
    bit             order_bad;
    logic [IDB-1:0] got [NP];
    int             ngot;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act_v,
                       input logic [31:0] exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    // Bus model acting as the bit-slot engine plus devices (wired-AND).
    initial begin
        slot_done = 1'b0;
        slot_rbit = 1'b0;
        forever begin
            @(negedge clk);
            if (slot_req) begin
                logic rb;
                rb = 1'b1;
                case (slot_kind)
                    2'd0: begin
                        rb    = ghost || (pres != '0);
                        act   = pres;
                        cmd_n = 0;
                        sub   = 0;
                        bpos  = 0;
                        cmd_v = 8'h00;
                    end
                    2'd2: begin
                        if (cmd_n < 8) begin
                            cmd_v[cmd_n] = slot_wbit;
                            cmd_n++;
                            if (cmd_n == 8 && cmd_v != 8'hF0) cmd_bad = 1;
                        end else begin
                            if (sub != 2 || bpos >= IDB) order_bad = 1;
                            else
                                for (int k = 0; k < NP; k++)
                                    if (act[k] && ids[k][bpos] != slot_wbit) act[k] = 1'b0;
                            sub = 0;
                            bpos++;
                        end
                    end
                    2'd1: begin
                        if (cmd_n < 8 || sub == 2 || bpos >= IDB) order_bad = 1;
                        else
                            for (int k = 0; k < NP; k++)
                                if (act[k])
                                    rb = rb & ((sub == 0) ? ids[k][bpos] : ~ids[k][bpos]);
                        sub++;
                    end
                    default: order_bad = 1;
                endcase
                @(negedge clk);
                slot_done = 1'b1;
                slot_rbit = rb;
                @(negedge clk);
                slot_done = 1'b0;
                slot_rbit = 1'b0;
            end
        end
    end

    task automatic run(input logic [NP-1:0] mask, input bit gh, input bit exp_err,
                       input string errtag);
        logic [IDB-1:0] e [NP];
        logic [IDB-1:0] tmp;
        int n;
        int ne;
        int t;
        bit seen;
        n = 0;
        pres = mask;
        ghost = gh;
        cmd_bad = 0;
        order_bad = 0;
        ngot = 0;
        for (int k = 0; k < NP; k++)
            if (mask[k]) begin
                e[n] = ids[k];
                n++;
            end
        for (int i = 0; i < n; i++)
            for (int j = 0; j < n - 1 - i; j++)
                if (rev(e[j]) > rev(e[j+1])) begin
                    tmp = e[j];
                    e[j] = e[j+1];
                    e[j+1] = tmp;
                end
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        t = 0;
        while (!seen && t < 30000) begin
            @(negedge clk);
            t++;
            if (id_valid) begin
                if (ngot < NP) got[ngot] = id_data;
                ngot++;
            end
            if (search_done) seen = 1;
        end
        chk(seen, "R9 search_done pulse", 32'(seen), 1);
        chk(search_err == exp_err, errtag, 32'(search_err), 32'(exp_err));
        chk(cmd_bad == 0, "R3 command byte 0xF0 LSB first", 32'(cmd_v), 32'hF0);
        chk(order_bad == 0, "R4 read/read/write slot order", 32'(order_bad), 0);
        @(negedge clk);
        chk(!busy && !slot_req, "R5/R9 no slot after end", 32'({busy, slot_req}), 0);
        if (exp_err) begin
            chk(dev_count == 0, "R5/R8 count zero on error", 32'(dev_count), 0);
        end else begin
            ne = (n < MAXD) ? n : MAXD;
            if (n == 0)
                chk(dev_count == 0, "R2 empty bus count", 32'(dev_count), 0);
            else
                chk(dev_count == CW'(n), "R9 device count", 32'(dev_count), 32'(n));
            chk(ngot == ne, "R10 emitted identifiers", 32'(ngot), 32'(ne));
            for (int i = 0; i < ne && i < ngot; i++)
                chk(got[i] == e[i], "R7 identifier order", 32'(got[i]), 32'(e[i]));
            if (n == 1 && ngot == 1)
                chk(got[0] == e[0], "R6 single device path", 32'(got[0]), 32'(e[0]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog R9 actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lows [NP];
        lows[0] = 8'h00;
        lows[1] = 8'h01;
        lows[2] = 8'h80;
        lows[3] = 8'h81;
        lows[4] = 8'h3C;
        for (int k = 0; k < NP; k++) ids[k] = {crc8(lows[k]), lows[k]};
        pres  = '0;
        ghost = 1'b0;
        act   = '0;
        start = 1'b0;
        rst   = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !slot_req && !id_valid && !search_done && !search_err && dev_count == 0,
            "R1 reset state",
            32'({busy, slot_req, id_valid, search_done, search_err, dev_count}), 0);

        // All subsets of the pool, including the empty bus (R2).
        for (int m = 0; m < (1 << NP); m++)
            run(NP'(m), 1'b0, 1'b0, (m == 0) ? "R2 no presence no error" : "R9 no error");

        // Presence but no bits driven: both reads high (R5).
        run('0, 1'b1, 1'b1, "R5 silent pair error");

        // Corrupted CRC byte, alone and behind a good identifier (R8).
        ids[4] = {crc8(8'h5A) ^ 8'h01, 8'h5A};
        run(5'b10000, 1'b0, 1'b1, "R8 crc mismatch error");
        run(5'b10001, 1'b0, 1'b1, "R8 crc mismatch after good id");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule